// File: doc/BRIEF.md
# Microsecond Timer Unit

The block keeps three 32-bit counters that all step on one shared tick. A prescaler produces the tick from the reference clock. The first counter is a time base that runs freely. Writes from software cannot change it. The other two counters are interval timers. Software loads each one through its own write strobe, using a common 32-bit data input. Each timer raises its own interrupt line when it is about to roll over from all ones to zero.

The prescaler divides the reference clock by a parameter `DIV`, which may be 2 to 16. It produces one tick cycle every `DIV` clock cycles. The first tick falls exactly one prescaler period after reset is released.

A timer load that lands in the cycle just before a tick cancels that timer's increment for the tick. A load in the tick cycle itself overrides the increment. The interrupt is a one-cycle pulse that coincides with the tick that wraps the timer.

Top module: `usec_timer_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the edge sets `time_base`, `tmr_a`, `tmr_b`, `irq_a` and `irq_b` to zero.
- R2: Clock edges during reset advance neither the prescaler nor any counter, even if write strobes are active. After release, the prescaler restarts from the same phase.
- R3: A clock edge with `wr_a` (or `wr_b`) high loads `wr_data` into that timer only. The value shows on the timer's output in the next cycle. The other timer and `time_base` are not disturbed.
- R4: On each tick, `time_base` and every timer that is not loaded or suppressed add one. The timers wrap from FFFFFFFF to 00000000.
- R5: Cycles are counted after reset release, starting at 0. The tick is active in cycle n exactly when n mod DIV equals DIV-1. A counter therefore first shows 1 after DIV edges.
- R6: A timer's interrupt is high only in a tick cycle in which the timer holds FFFFFFFF and its increment is not suppressed. In the following cycle that timer reads zero.
- R7: A timer loaded in the cycle directly before a tick keeps the loaded value through that tick, and raises no interrupt for it. It resumes counting on the next tick.
- R8: When a timer's write strobe is high in a tick cycle, the load wins and that tick's increment is dropped for that timer.
- R9: `time_base` ignores both write strobes.
- R10: A timer loaded with FFFFFFFE away from a tick raises its interrupt on the second tick it counts, not the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_a | input | 1 | Load strobe for timer A |
| wr_b | input | 1 | Load strobe for timer B |
| wr_data | input | 32 | Value to load |
| time_base | output | 32 | Free-running counter |
| tmr_a | output | 32 | Timer A value |
| tmr_b | output | 32 | Timer B value |
| irq_a | output | 1 | Timer A roll-over interrupt |
| irq_b | output | 1 | Timer B roll-over interrupt |

## Verification
A prescaler phase error shows on all three counters at once. It appears at the first tick after release, within DIV cycles, as a counter that steps one cycle early or late.

A stuck suppression flag in a timer freezes that timer at the next tick. A suppression flag that is never set lets the timer count on a tick right after a load. Either fault diverges at the port one cycle after that tick.

An interrupt computed from the wrong tick phase appears as a pulse in the wrong cycle. An interrupt that ignores suppression appears as a pulse on a held all-ones value. The bench places loads at each prescaler phase that matters, so each of these faults shows at the ports.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;
    localparam int PS_W = 4;

    // First prescaler state, chosen so that the states from it up to all ones,
    // plus one tick cycle, make up exactly div cycles.
    function automatic logic [PS_W-1:0] ps_first(input int div);
        int v;
        v = (1 << PS_W) + 1 - div;
        return v[PS_W-1:0];
    endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import usec_timer_pkg::*;
#(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick,
    output logic tick_next
);
    localparam logic [PS_W-1:0] PS_START = ps_first(DIV);
    localparam logic [PS_W-1:0] PS_LAST  = '1;

    typedef struct packed {
        logic [PS_W-1:0] ps;
        logic            tick;
    } ps_state_t;

    ps_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.tick) begin
            st_d.tick = 1'b0;
            st_d.ps   = PS_START;
        end else if (st_q.ps == PS_LAST) begin
            st_d.tick = 1'b1;
        end else begin
            st_d.ps = st_q.ps + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ps   <= PS_START;
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick      = st_q.tick;
    assign tick_next = st_d.tick;

    // R5
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R5
    tick_announced_chk: assert property (@(posedge clk) disable iff (rst)
        tick_next |=> tick);
endmodule

// File: rtl/freerun_counter.sv
module freerun_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    output logic [W-1:0] count
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } fr_state_t;

    fr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.cnt <= '0;
        else     st_q     <= st_d;
    end

    assign count = st_q.cnt;

    // R4
    base_step_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> count == $past(count) + 1'b1);

    // R9
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] din,
    input  logic         tick,
    input  logic         tick_next,
    output logic [W-1:0] value,
    output logic         irq
);
    localparam logic [W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [W-1:0] val;
        logic         skip;
        logic         irq;
    } tm_state_t;

    tm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.val  = din;
            st_d.skip = tick_next;
        end else if (tick) begin
            st_d.skip = 1'b0;
            if (!st_q.skip) st_d.val = st_q.val + 1'b1;
        end
        st_d.irq = tick_next && (st_d.val == ALL_ONES) && !st_d.skip;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.val  <= '0;
            st_q.skip <= 1'b0;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.val;
    assign irq   = st_q.irq;

    // R3
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        ld |=> value == $past(din));

    // R6
    irq_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> tick && value == ALL_ONES);

    // R6
    irq_wraps_chk: assert property (@(posedge clk) disable iff (rst)
        irq && !ld |=> value == '0);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick && !ld |=> $stable(value));
endmodule

// File: rtl/usec_timer_unit.sv
module usec_timer_unit #(
    parameter int DIV   = 8,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_a,
    input  logic             wr_b,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] time_base,
    output logic [CNT_W-1:0] tmr_a,
    output logic [CNT_W-1:0] tmr_b,
    output logic             irq_a,
    output logic             irq_b
);
    localparam int N_TMR = 2;

    logic             tick, tick_next;
    logic [N_TMR-1:0] ld_vec;
    logic [N_TMR-1:0] irq_vec;
    logic [CNT_W-1:0] val_arr [N_TMR];

    assign ld_vec = {wr_b, wr_a};

    tick_prescaler #(.DIV(DIV)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .tick_next (tick_next)
    );

    freerun_counter #(.W(CNT_W)) u_base (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .count (time_base)
    );

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        interval_timer #(.W(CNT_W)) u_tmr (
            .clk       (clk),
            .rst       (rst),
            .ld        (ld_vec[i]),
            .din       (wr_data),
            .tick      (tick),
            .tick_next (tick_next),
            .value     (val_arr[i]),
            .irq       (irq_vec[i])
        );
    end

    assign tmr_a = val_arr[0];
    assign tmr_b = val_arr[1];
    assign irq_a = irq_vec[0];
    assign irq_b = irq_vec[1];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> time_base == '0 && tmr_a == '0 && tmr_b == '0 && !irq_a && !irq_b);

    // R8
    load_beats_tick_chk: assert property (@(posedge clk) disable iff (rst)
        tick && wr_a |=> tmr_a == $past(wr_data));
endmodule

// File: tb/tb_usec_timer_unit.sv
`timescale 1ns/1ps
module tb_usec_timer_unit;
    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst, wr_a, wr_b;
    logic [31:0] wr_data;
    logic [31:0] time_base, tmr_a, tmr_b;
    logic        irq_a, irq_b;

    always #2.5 clk = ~clk;

    usec_timer_unit #(.DIV(DIV), .CNT_W(32)) dut (
        .clk(clk), .rst(rst), .wr_a(wr_a), .wr_b(wr_b), .wr_data(wr_data),
        .time_base(time_base), .tmr_a(tmr_a), .tmr_b(tmr_b),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    typedef struct {
        logic [31:0] base, a, b;
        logic        ia, ib;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0, n_fail = 0;
    bit   done = 0;

    // Behavioural model, indexed by the cycle count since reset release
    int          m_c = 0;
    logic [31:0] m_base = 0;
    logic [31:0] m_v [2];
    bit          m_skip [2];
    bit          m_irq [2];

    function automatic bit tick_at(input int c);
        return (c % DIV) == DIV - 1;
    endfunction

    task automatic step(input logic r, input logic wa, input logic wb,
                        input logic [31:0] d, input string tag);
        exp_t e;
        bit   wr [2];
        rst = r; wr_a = wa; wr_b = wb; wr_data = d;
        wr[0] = wa; wr[1] = wb;
        if (r) begin
            m_c = 0; m_base = 0;
            for (int i = 0; i < 2; i++) begin
                m_v[i] = 0; m_skip[i] = 0; m_irq[i] = 0;
            end
        end else begin
            if (tick_at(m_c)) m_base = m_base + 1;
            for (int i = 0; i < 2; i++) begin
                if (wr[i]) begin
                    m_v[i] = d; m_skip[i] = tick_at(m_c + 1);
                end else if (tick_at(m_c)) begin
                    if (m_skip[i]) m_skip[i] = 0;
                    else m_v[i] = m_v[i] + 1;
                end
                m_irq[i] = tick_at(m_c + 1) && (m_v[i] == 32'hFFFF_FFFF) && !m_skip[i];
            end
            m_c++;
        end
        e.base = m_base; e.a = m_v[0]; e.b = m_v[1];
        e.ia = m_irq[0]; e.ib = m_irq[1]; e.tag = tag;
        exp_q.push_back(e);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(0, 0, 0, 32'h0, tag);
    endtask

    task automatic to_phase(input int p, input string tag);
        while ((m_c % DIV) != p) step(0, 0, 0, 32'h0, tag);
    endtask

    // Monitor: compare each edge's result against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (time_base !== e.base || tmr_a !== e.a || tmr_b !== e.b ||
                    irq_a !== e.ia || irq_b !== e.ib) begin
                    n_fail++;
                    $display("FAIL %s: actual base=%h a=%h b=%h ia=%b ib=%b expected base=%h a=%h b=%h ia=%b ib=%b",
                             e.tag, time_base, tmr_a, tmr_b, irq_a, irq_b,
                             e.base, e.a, e.b, e.ia, e.ib);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1 R2: reset clears, strobes during reset ignored
        step(1, 1, 1, 32'h0000_0000, "R1");
        step(1, 1, 1, 32'hDEAD_BEEF, "R2");
        step(1, 0, 0, 32'h0, "R2");
        step(1, 0, 1, 32'h1111_1111, "R2");
        // R3 R9: back-to-back loads, base untouched
        step(0, 1, 0, 32'h0123_4567, "R3");
        step(0, 0, 1, 32'h89AB_CDEF, "R3");
        step(0, 1, 0, 32'hFFFF_FFFE, "R9");
        step(0, 0, 1, 32'h0123_4567, "R3");
        // R5 R4: first tick lands DIV cycles after release
        idle(DIV, "R5");
        // R10 R6: A goes FE -> FF -> irq -> wraps to 0
        idle(2 * DIV, "R10");
        idle(DIV, "R4");
        // R7: load B just before a tick, tick skipped
        to_phase(DIV - 2, "R4");
        step(0, 0, 1, 32'hFFFF_FFFE, "R7");
        idle(DIV, "R7");
        idle(3 * DIV, "R6");
        // R8: load A in the tick cycle, load wins
        to_phase(DIV - 1, "R4");
        step(0, 1, 0, 32'h0000_0100, "R8");
        idle(DIV, "R8");
        // R6: A loaded with all ones mid-period interrupts on next tick
        to_phase(2, "R4");
        step(0, 1, 0, 32'hFFFF_FFFF, "R6");
        idle(2 * DIV, "R6");
        // R7: all ones loaded just before a tick gives no irq that tick
        to_phase(DIV - 2, "R4");
        step(0, 0, 1, 32'hFFFF_FFFF, "R7");
        idle(2 * DIV + 2, "R7");
        // R9: strobes at many phases leave base counting
        for (int k = 0; k < DIV; k++) step(0, 1, 1, 32'h5555_0000 + k, "R9");
        idle(DIV, "R9");
        // R2: reset mid-run and release restarts from the same phase
        step(1, 0, 0, 32'h0, "R1");
        step(1, 1, 0, 32'h7, "R2");
        idle(2 * DIV, "R2");
        @(posedge clk);
        #3;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule